// File: doc/BRIEF.md
# Bit-Serial Magnitude Comparator

This block compares two operands that arrive one bit per clock on a pair of serial lines, lowest-order bit first. After every accepted bit it reports how the two values seen so far relate. The bit just accepted counts as the most significant bit, so each result reflects the operands as if they ended at that bit. Three base relations are kept: equality, unsigned less-than and unsigned greater-than. The signed less-than and greater-than results are rebuilt on every bit from the running unsigned results, with the newest bit taken as the two's-complement sign. Less-or-equal and greater-or-equal are formed from these for both interpretations.

A stream opens with a bit that has both `start` and `bitValid` high. That bit replaces all earlier history. The following bits carry `bitValid` high and `start` low. Cycles with `bitValid` low leave every result unchanged, so the source may pause between bits. A `start` pulse without `bitValid` returns the results to their idle values without taking a bit. All results are registered and change on the clock edge that accepts a bit.

Top module: `serial_compare`

## Requirements
- R1: After reset, `eqOut` is 1 and every less-than and greater-than output is 0; `uleOut`, `ugeOut`, `sleOut` and `sgeOut` are 1.
- R2: `eqOut` is 1 exactly when every bit pair accepted since the opening bit matched. After one mismatch it stays 0 until the next stream opens.
- R3: After the clock edge that accepts bit n (counting from 0), `ultOut` and `ugtOut` give the unsigned comparison of the bits 0..n of a against those of b.
- R4: After the same edge, `sltOut` and `sgtOut` give the comparison of those n+1 bits read as two's-complement values with bit n as the sign. A single-bit operand with value 1 counts as -1.
- R5: `uleOut` = `ultOut` | `eqOut`, `ugeOut` = `ugtOut` | `eqOut`, `sleOut` = `sltOut` | `eqOut`, `sgeOut` = `sgtOut` | `eqOut`.
- R6: A cycle with `bitValid` low and `start` low changes no output.
- R7: A bit accepted with `start` high is bit 0 of a new operand pair, and no earlier bit affects any result.
- R8: `start` high with `bitValid` low returns all outputs to their R1 values on the next edge.
- R9: Exactly one of `eqOut`, `ultOut`, `ugtOut` is 1 at all times, and exactly one of `eqOut`, `sltOut`, `sgtOut` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new stream (with `bitValid`) or clears results (without it) |
| bitValid | input | 1 | The serial bits are presented this cycle |
| aBit | input | 1 | Serial bit of operand a, lowest order first |
| bBit | input | 1 | Serial bit of operand b, lowest order first |
| eqOut | output | 1 | Operands equal so far |
| ultOut | output | 1 | a < b, unsigned |
| ugtOut | output | 1 | a > b, unsigned |
| uleOut | output | 1 | a <= b, unsigned |
| ugeOut | output | 1 | a >= b, unsigned |
| sltOut | output | 1 | a < b, signed, newest bit as sign |
| sgtOut | output | 1 | a > b, signed, newest bit as sign |
| sleOut | output | 1 | a <= b, signed |
| sgeOut | output | 1 | a >= b, signed |

## Verification
The assertions check these on every cycle: equality never recovers inside a stream, the outputs freeze during idle cycles, and a clear without a bit restores the idle values. They also check that each relation triple stays one-hot and that a differing bit pair sets the signed results from the a and b bits. Whether the unsigned and signed results match the full arithmetic value of long operands can only be shown by the bench's scenarios. The same holds for a new stream fully discarding the old one. The bench streams equal words, words that differ only in low bits, sign-crossing pairs, pauses between bits and random words, and compares against values it computes itself.

// File: rtl/serial_compare_pkg.sv
package serial_compare_pkg;

  // Strobes from the control to the datapath for one cycle.
  typedef struct packed {
    logic clr;    // restore idle results, take no bit
    logic step;   // accept the serial bit pair
    logic fresh;  // the accepted bit opens a new stream
  } cmpStrobe_t;

  // Registered relation flags.
  typedef struct packed {
    logic eq;
    logic ult;
    logic ugt;
    logic slt;
    logic sgt;
  } cmpFlags_t;

  localparam cmpFlags_t FLAGS_IDLE = '{eq: 1'b1, ult: 1'b0, ugt: 1'b0, slt: 1'b0, sgt: 1'b0};

endpackage

// File: rtl/serial_compare_ctrl.sv
module serial_compare_ctrl
  import serial_compare_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       bitValid,
  output cmpStrobe_t strobe
);

  always_comb begin
    strobe.step  = bitValid;
    strobe.fresh = bitValid & start;
    strobe.clr   = start & ~bitValid;
  end

  // R7/R8: clear and bit acceptance never coincide, and a fresh bit is a step
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.clr && strobe.step));
  assert_fresh_is_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fresh |-> strobe.step);

endmodule

// File: rtl/serial_compare_dp.sv
module serial_compare_dp
  import serial_compare_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cmpStrobe_t strobe,
  input  logic       aBit,
  input  logic       bBit,
  output cmpFlags_t  flags
);

  cmpFlags_t flagsQ;
  cmpFlags_t flagsD;
  logic      sameBit;
  logic      prevEq;
  logic      prevUlt;
  logic      prevUgt;

  // A fresh bit compares against an empty history
  always_comb begin
    prevEq  = strobe.fresh ? 1'b1 : flagsQ.eq;
    prevUlt = strobe.fresh ? 1'b0 : flagsQ.ult;
    prevUgt = strobe.fresh ? 1'b0 : flagsQ.ugt;
    sameBit = ~(aBit ^ bBit);

    flagsD.eq  = prevEq & sameBit;
    flagsD.ult = (~aBit & bBit) | (sameBit & prevUlt);
    flagsD.ugt = (aBit & ~bBit) | (sameBit & prevUgt);
    // newest bit is the sign: a differing sign decides directly
    flagsD.slt = sameBit ? flagsD.ult : aBit;
    flagsD.sgt = sameBit ? flagsD.ugt : bBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            flagsQ <= FLAGS_IDLE;
    else if (strobe.clr)  flagsQ <= FLAGS_IDLE;
    else if (strobe.step) flagsQ <= flagsD;
  end

  assign flags = flagsQ;

  // R2: equality never recovers inside a stream
  assert_eq_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.fresh && !flagsQ.eq) |=> !flagsQ.eq);
  // R6: idle cycles freeze every flag
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.clr) |=> $stable(flagsQ));
  // R8: clear restores idle flags
  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (flagsQ.eq && !flagsQ.ult && !flagsQ.ugt && !flagsQ.slt && !flagsQ.sgt));
  // R9: relation triples are one-hot
  assert_unsigned_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({flagsQ.eq, flagsQ.ult, flagsQ.ugt}) == 1);
  assert_signed_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({flagsQ.eq, flagsQ.slt, flagsQ.sgt}) == 1);
  // R4: differing sign bits decide the signed result
  assert_sign_decides_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && (aBit != bBit)) |=> (flagsQ.slt == $past(aBit) && flagsQ.sgt == $past(bBit)));

endmodule

// File: rtl/serial_compare.sv
module serial_compare
  import serial_compare_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic bitValid,
  input  logic aBit,
  input  logic bBit,
  output logic eqOut,
  output logic ultOut,
  output logic ugtOut,
  output logic uleOut,
  output logic ugeOut,
  output logic sltOut,
  output logic sgtOut,
  output logic sleOut,
  output logic sgeOut
);

  cmpStrobe_t strobe;
  cmpFlags_t  flags;

  serial_compare_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .bitValid (bitValid),
    .strobe   (strobe)
  );

  serial_compare_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .aBit   (aBit),
    .bBit   (bBit),
    .flags  (flags)
  );

  assign eqOut  = flags.eq;
  assign ultOut = flags.ult;
  assign ugtOut = flags.ugt;
  assign sltOut = flags.slt;
  assign sgtOut = flags.sgt;
  // R5: inclusive relations
  assign uleOut = flags.ult | flags.eq;
  assign ugeOut = flags.ugt | flags.eq;
  assign sleOut = flags.slt | flags.eq;
  assign sgeOut = flags.sgt | flags.eq;

endmodule

// File: tb/test_serial_compare.sv
module test_serial_compare;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, bitValid = 1'b0, aBit = 1'b0, bBit = 1'b0;
  logic eqOut, ultOut, ugtOut, uleOut, ugeOut, sltOut, sgtOut, sleOut, sgeOut;

  always #5 clk = ~clk;

  serial_compare i_serial_compare (
    .clk(clk), .rstN(rstN), .start(start), .bitValid(bitValid),
    .aBit(aBit), .bBit(bBit),
    .eqOut(eqOut), .ultOut(ultOut), .ugtOut(ugtOut), .uleOut(uleOut), .ugeOut(ugeOut),
    .sltOut(sltOut), .sgtOut(sgtOut), .sleOut(sleOut), .sgeOut(sgeOut)
  );

  typedef struct {
    logic  eq, ult, ugt, slt, sgt;
    string ctx;
  } expItem_t;

  expItem_t    expQ[$];
  int          checks = 0;
  int          fails = 0;
  logic [63:0] aVal = '0, bVal = '0;
  int          nBits = 0;
  bit          done = 0;

  task automatic chk(string req, string ctx, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): actual %b expected %b", req, ctx, act, exp);
    end
  endtask

  function automatic expItem_t modelNow(string ctx);
    expItem_t it;
    logic [63:0] flip;
    if (nBits == 0) begin
      it.eq = 1; it.ult = 0; it.ugt = 0; it.slt = 0; it.sgt = 0;
    end else begin
      flip = 64'd1 << (nBits - 1);
      it.eq  = (aVal == bVal);
      it.ult = (aVal < bVal);
      it.ugt = (aVal > bVal);
      it.slt = ((aVal ^ flip) < (bVal ^ flip));
      it.sgt = ((aVal ^ flip) > (bVal ^ flip));
    end
    it.ctx = ctx;
    return it;
  endfunction

  task automatic drive(logic s, logic v, logic a, logic b, string ctx);
    @(negedge clk);
    start = s; bitValid = v; aBit = a; bBit = b;
    if (s && !v) begin
      nBits = 0; aVal = '0; bVal = '0;
    end else if (v) begin
      if (s) begin nBits = 0; aVal = '0; bVal = '0; end
      aVal[nBits] = a; bVal[nBits] = b; nBits++;
    end
    expQ.push_back(modelNow(ctx));
  endtask

  task automatic sendWord(logic [63:0] a, logic [63:0] b, int w, string ctx);
    for (int i = 0; i < w; i++) drive(i == 0, 1'b1, a[i], b[i], ctx);
  endtask

  // monitor: compare one expectation per clock after the edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      chk("R2", e.ctx, eqOut, e.eq);
      chk("R3", e.ctx, ultOut, e.ult);
      chk("R3", e.ctx, ugtOut, e.ugt);
      chk("R4", e.ctx, sltOut, e.slt);
      chk("R4", e.ctx, sgtOut, e.sgt);
      chk("R5", e.ctx, uleOut, e.ult | e.eq);
      chk("R5", e.ctx, ugeOut, e.ugt | e.eq);
      chk("R5", e.ctx, sleOut, e.slt | e.eq);
      chk("R5", e.ctx, sgeOut, e.sgt | e.eq);
      chk("R9", e.ctx, 1'($countones({eqOut, ultOut, ugtOut}) == 1), 1'b1);
      chk("R9", e.ctx, 1'($countones({eqOut, sltOut, sgtOut}) == 1), 1'b1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset", eqOut, 1'b1);
    chk("R1", "reset", ultOut, 1'b0);
    chk("R1", "reset", ugtOut, 1'b0);
    chk("R1", "reset", sltOut, 1'b0);
    chk("R1", "reset", sgtOut, 1'b0);
    chk("R1", "reset", uleOut & ugeOut & sleOut & sgeOut, 1'b1);
    @(negedge clk); rstN = 1'b1;

    sendWord(64'h5A, 64'h5A, 8, "R2 equal word");
    sendWord(64'h0F0, 64'h0F1, 12, "R2 R3 low-bit differs then matches");
    sendWord(64'h3, 64'hC, 4, "R3 R4 unsigned small vs large");
    sendWord(64'h7, 64'h7, 4, "R4 example positive");
    sendWord(64'hE, 64'h7, 4, "R4 negative vs positive");
    sendWord(64'h1, 64'h0, 1, "R4 single bit");
    // R6 pauses within a stream
    drive(1, 1, 1, 0, "R6 first bit");
    drive(0, 0, 0, 1, "R6 idle ignores bits");
    drive(0, 0, 1, 1, "R6 idle ignores bits");
    drive(0, 1, 0, 1, "R6 after pause");
    drive(0, 0, 1, 0, "R6 idle again");
    // R7 restart mid-stream discards history
    drive(0, 1, 1, 0, "R7 prior bit");
    drive(1, 1, 0, 0, "R7 restart equal");
    drive(0, 1, 1, 1, "R7 restart continues");
    // R8 clear without a bit
    drive(0, 1, 0, 1, "R8 before clear");
    drive(1, 0, 1, 0, "R8 clear");
    drive(0, 0, 0, 0, "R8 idle after clear");
    for (int k = 0; k < 40; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (k % 3 == 0) ? ra ^ (64'd1 << (k % 40)) : {$urandom, $urandom};
      sendWord(ra, rb, 8 + (k % 50), "R3 R4 random");
    end
    drive(0, 0, 0, 0, "R6 tail");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule